// File: doc/BRIEF.md
# Mirrored Two-Read One-Write Word Memory

This block is a word-wide memory with two read ports and one write port. It gets its second read port from a second copy of a plain single-port array, not from a multi-ported storage cell. A read cycle sends read address A to copy 0 and read address B to copy 1, so two words come out together. A write cycle stores the same word at the same address in both copies, which keeps the two copies identical at all times.

Reads and writes use separate cycles. The expected pattern is the one a register file follows: one cycle reads two operands, and a later cycle writes one result back. Reads are synchronous. An address taken on a clock edge gives its data after that edge, and a valid strobe for each port rises at the same time. If a caller requests both a read and a write in one cycle, the write is performed, the read is dropped, and a collision flag is raised for one cycle.

The address width is a parameter. The default of 10 bits gives 1024 words per copy, which keeps simulation small. Setting it to 15 gives 32K words, the size that a 16-bit byte pointer covers.

Top module: `mirmem_2r1w`

## Requirements
- R1: Each word is DATA_W bits wide (default 16). Each copy holds 2**ADDR_W words, addressed by an ADDR_W-bit word address.
- R2: A read cycle (rdEn=1, wrEn=0) samples rdAddrA and rdAddrB on a rising edge. After that edge, rdDataA and rdDataB show the stored words, and rdValidA and rdValidB are 1 for one cycle.
- R3: In a read cycle, the two ports read two different addresses independently and at the same time.
- R4: A write cycle (wrEn=1) stores wrData at wrAddr in both copies. A later read of that address returns the written word on port A and on port B.
- R5: In the cycle after a write cycle, rdValidA and rdValidB are 0.
- R6: When rdEn and wrEn are both 1, the write is performed and both valids are 0 in the next cycle. The collision output is 1 for exactly that one cycle.
- R7: In the cycle after an idle cycle (rdEn=0, wrEn=0), both valids are 0. After an idle, write or collision cycle, rdDataA and rdDataB keep the value of the last read.
- R8: While rstN is low, rdValidA, rdValidB and collision are 0. Reset does not change the stored words.
- R9: In the cycle after any cycle that does not have both rdEn and wrEn at 1, collision is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the valid and collision outputs |
| rdEn | input | 1 | Requests a read cycle |
| rdAddrA | input | ADDR_W | Word address for read port A (served by copy 0) |
| rdAddrB | input | ADDR_W | Word address for read port B (served by copy 1) |
| wrEn | input | 1 | Requests a write cycle; takes priority over rdEn |
| wrAddr | input | ADDR_W | Word address for the write |
| wrData | input | DATA_W | Word to be written to both copies |
| rdDataA | output | DATA_W | Registered read data of port A |
| rdDataB | output | DATA_W | Registered read data of port B |
| rdValidA | output | 1 | Port A data was loaded by the previous cycle |
| rdValidB | output | 1 | Port B data was loaded by the previous cycle |
| collision | output | 1 | One-cycle flag: read and write were requested together |

## Verification
The hardest fault to expose from the ports is one copy drifting away from the other, for example a write that reaches only one copy. Reading through one port alone would never show it. The stimulus therefore first fills every address through the write port. It then mixes random writes with reads whose two addresses are often forced equal or set to a word that was just written, so that each copy is compared against one shared reference array through its own port. Collision cycles and idle cycles are placed between the reads so that every path that holds the data is exercised.

// File: rtl/mirmem_pkg.sv
package mirmem_pkg;
  localparam int COPIES = 2;

  typedef struct packed {
    logic wr;
    logic rd;
  } mirStrobe_t;
endpackage

// File: rtl/mirmem_bank.sv
module mirmem_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single-port array: one access per cycle, write takes the port.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= din;
    end else if (re) begin
      dout <= mem[addr];
    end
  end
endmodule

// File: rtl/mirmem_datapath.sv
module mirmem_datapath
  import mirmem_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  mirStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [COPIES-1:0][ADDR_W-1:0] portAddr;
  logic [COPIES-1:0][DATA_W-1:0] portData;

  assign portAddr[0] = rdAddrA;
  assign portAddr[1] = rdAddrB;

  for (genvar g = 0; g < COPIES; g++) begin : gCopy
    logic [ADDR_W-1:0] bankAddr;
    assign bankAddr = strobe.wr ? wrAddr : portAddr[g];

    mirmem_bank #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
    ) i_bank (
      .clk (clk),
      .we  (strobe.wr),
      .re  (strobe.rd),
      .addr(bankAddr),
      .din (wrData),
      .dout(portData[g])
    );
  end

  assign rdDataA = portData[0];
  assign rdDataB = portData[1];

  // R7: read data holds whenever the cycle is not a read
  assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rd |=> $stable(rdDataA));
  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rd |=> $stable(rdDataB));
  // R4: a write addresses both copies at the write address
  assert_write_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr |-> (gCopy[0].bankAddr == wrAddr) && (gCopy[1].bankAddr == wrAddr));
endmodule

// File: rtl/mirmem_ctrl.sv
module mirmem_ctrl
  import mirmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  logic       wrEn,
  output mirStrobe_t strobe,
  output logic       rdValid,
  output logic       collision
);
  // Write owns the cycle; a read only happens alone.
  always_comb begin
    strobe.wr = wrEn;
    strobe.rd = rdEn & ~wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      collision <= 1'b0;
    end else begin
      rdValid   <= strobe.rd;
      collision <= rdEn & wrEn;
    end
  end

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid);
  assert_no_valid_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !rdValid);
  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |=> collision);
  assert_no_false_collision_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn) |=> !collision);
  assert_idle_invalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !wrEn) |=> !rdValid);
  assert_never_both_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && collision));
endmodule

// File: rtl/mirmem_2r1w.sv
module mirmem_2r1w
  import mirmem_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdValidA,
  output logic              rdValidB,
  output logic              collision
);
  mirStrobe_t strobe;
  logic       rdValid;

  mirmem_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .strobe   (strobe),
    .rdValid  (rdValid),
    .collision(collision)
  );

  mirmem_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );

  assign rdValidA = rdValid;
  assign rdValidB = rdValid;

  // R8: outputs cleared while reset is held
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> (!rdValidA && !rdValidB && !collision));
endmodule

// File: tb/test_mirmem_2r1w.sv
module test_mirmem_2r1w;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rdEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] rdAddrA = '0;
  logic [ADDR_W-1:0] rdAddrB = '0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdDataA, rdDataB;
  logic              rdValidA, rdValidB, collision;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] expA = '0;
  logic [DATA_W-1:0] expB = '0;

  always #4 clk = ~clk;

  mirmem_2r1w #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mirmem_2r1w (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdDataA(rdDataA),
    .rdDataB(rdDataB), .rdValidA(rdValidA), .rdValidB(rdValidB),
    .collision(collision)
  );

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // One clock cycle: drive at negedge, then check the registered outputs.
  task automatic doCycle(input bit rd, input bit wr, input int aA, input int aB,
                         input int wa, input logic [DATA_W-1:0] wd, input string tag);
    bit expValid;
    @(negedge clk);
    rdEn = rd; wrEn = wr;
    rdAddrA = aA[ADDR_W-1:0]; rdAddrB = aB[ADDR_W-1:0];
    wrAddr = wa[ADDR_W-1:0]; wrData = wd;
    expValid = rd && !wr;
    if (wr) refMem[wa] = wd;
    else if (rd) begin
      expA = refMem[aA];
      expB = refMem[aB];
    end
    @(posedge clk);
    #2;
    check({tag, " validA"}, 32'(rdValidA), 32'(expValid));
    check({tag, " validB"}, 32'(rdValidB), 32'(expValid));
    check({tag, " collision R6 R9"}, 32'(collision), 32'(rd && wr));
    check({tag, " dataA"}, 32'(rdDataA), 32'(expA));
    check({tag, " dataB"}, 32'(rdDataB), 32'(expB));
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R8: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset validA", 32'(rdValidA), 32'd0);
    check("R8 reset validB", 32'(rdValidB), 32'd0);
    check("R8 reset collision", 32'(collision), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: fill every word of the full depth through the single write port
    for (int i = 0; i < DEPTH; i++) begin
      doCycle(1'b0, 1'b1, 0, 0, i, DATA_W'($urandom), "R1 fill");
    end
    // R1: lowest and highest addresses, 16-bit patterns
    doCycle(1'b0, 1'b1, 0, 0, 0, 16'hFFFF, "R1 write low");
    doCycle(1'b0, 1'b1, 0, 0, DEPTH-1, 16'h8001, "R1 write high");
    doCycle(1'b1, 1'b0, 0, DEPTH-1, 0, '0, "R1 R3 read ends");
    doCycle(1'b1, 1'b0, DEPTH-1, 0, 0, '0, "R1 R3 read swapped");
    // R4: write then read the same address on both ports
    doCycle(1'b0, 1'b1, 0, 0, 77, 16'hA5C3, "R5 write");
    doCycle(1'b1, 1'b0, 77, 77, 0, '0, "R4 R2 read both");
    // R6: collision then read back the written word
    doCycle(1'b1, 1'b1, 12, 13, 300, 16'h1234, "R6 collide");
    doCycle(1'b0, 1'b0, 0, 0, 0, '0, "R7 idle");
    doCycle(1'b1, 1'b0, 300, 12, 0, '0, "R6 R3 read after collide");
    doCycle(1'b1, 1'b1, 5, 6, 301, 16'h4321, "R6 collide back-to-back");
    doCycle(1'b1, 1'b1, 5, 6, 302, 16'h0F0F, "R6 collide second");
    doCycle(1'b1, 1'b0, 301, 302, 0, '0, "R4 read pair");

    // Random interleaving against the single reference array
    for (int n = 0; n < 4000; n++) begin
      int op, aA, aB, wa;
      op = int'($urandom % 10);
      wa = int'($urandom % DEPTH);
      aA = int'($urandom % DEPTH);
      aB = ($urandom % 3 == 0) ? aA : int'($urandom % DEPTH);
      if ($urandom % 4 == 0) aA = wa;
      if (op < 4)       doCycle(1'b1, 1'b0, aA, aB, wa, '0, "R2 R3 rand read");
      else if (op < 7)  doCycle(1'b0, 1'b1, aA, aB, wa, DATA_W'($urandom), "R4 R5 rand write");
      else if (op < 8)  doCycle(1'b1, 1'b1, aA, aB, wa, DATA_W'($urandom), "R6 rand collide");
      else if (op < 9)  doCycle(1'b0, 1'b0, aA, aB, wa, '0, "R7 rand idle");
      else              doCycle(1'b1, 1'b0, wa, wa, wa, '0, "R4 rand same");
    end

    // R8: reset keeps contents
    doCycle(1'b0, 1'b1, 0, 0, 5, 16'hBEEF, "R8 pre-reset write");
    doCycle(1'b1, 1'b0, 5, 5, 0, '0, "R8 pre-reset read");
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; rstN = 1'b0;
    @(posedge clk);
    #2;
    check("R8 in reset validA", 32'(rdValidA), 32'd0);
    check("R8 in reset collision", 32'(collision), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    doCycle(1'b1, 1'b0, 5, 5, 0, '0, "R8 contents kept");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule